// File: doc/BRIEF.md
# Registered 8-bit Accumulator ALU

This block performs the data operations of a small 8-bit accumulator processor. Each clock it takes a register operand (the accumulator or an index register), a memory operand, the current carry and overflow flags and a 4-bit operation code. One clock later it presents a result, the four status flags (carry, zero, overflow, negative) and a write strobe. The write strobe tells the surrounding datapath whether the result should be written back to a register.

Arithmetic is binary only; there is no decimal mode. Subtraction adds the inverted operand, with the incoming carry acting as "no borrow". Compare runs the same subtraction with carry forced high and discards the difference. Bit-test copies two operand bits straight into the flags.

Top module: `alu8_top`

## Requirements
- R1: While `rst` is high at a rising edge, every output register clears to zero on that edge.
- R2: Outputs change only at a rising clock edge and reflect the inputs sampled at that edge: one cycle of latency. Operation codes: 0 OR, 1 AND, 2 XOR, 3 add, 4 subtract, 5 compare, 6 increment, 7 decrement, 8 shift left, 9 rotate left, 10 shift right, 11 rotate right, 12 bit-test.
- R3: OR, AND and XOR (codes 0–2) produce the bitwise result of the two operands. Zero means result==0 and negative is result bit 7. Carry and overflow echo `carry_in` and `ovf_in`. The write strobe is 1.
- R4: Add (code 3) gives (a+m+cin) mod 256. Carry is set when a+m+cin exceeds 255, and overflow is bit 7 of ((a^r)&(m^r)). The write strobe is 1.
- R5: Subtract (code 4) behaves exactly as add with m replaced by its bitwise complement, using the same `carry_in`.
- R6: Compare (code 5) sets carry when a>=m unsigned, takes zero and negative from (a−m) mod 256, echoes `ovf_in`, and drives the write strobe to 0.
- R7: Increment and decrement (codes 6 and 7) act on `acc_in` and wrap modulo 256. Only zero and negative are updated; carry and overflow echo their inputs. The write strobe is 1.
- R8: Shift left and rotate left (codes 8 and 9) move bit 7 into carry. Bit 0 receives 0 for the shift and the old carry for the rotate. Overflow is echoed.
- R9: Shift right and rotate right (codes 10 and 11) move bit 0 into carry. Bit 7 receives 0 for the shift and the old carry for the rotate. Overflow is echoed.
- R10: Bit-test (code 12) sets zero when (a&m)==0, negative from m bit 7 and overflow from m bit 6. Carry is echoed, the result equals `acc_in` and the write strobe is 0.
- R11: Unused codes 13–15 return `acc_in` with the write strobe at 0. Zero and negative follow `acc_in`, and carry and overflow are echoed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_sel | input | 4 | Operation code |
| acc_in | input | 8 | Register operand |
| mem_in | input | 8 | Memory operand |
| carry_in | input | 1 | Current carry flag |
| ovf_in | input | 1 | Current overflow flag |
| res_q | output | 8 | Registered result |
| c_q | output | 1 | Registered carry flag |
| z_q | output | 1 | Registered zero flag |
| v_q | output | 1 | Registered overflow flag |
| n_q | output | 1 | Registered negative flag |
| wr_q | output | 1 | Registered write-back strobe |

## Verification
The block keeps no state beyond its output registers, so any fault appears at the ports on the edge after the offending inputs are sampled. It cannot hide and surface later. A wrong operand inversion, carry route or overflow term shows up as a bad result or flag for a single operation code. It can be seen only for operand pairs that reach the affected bit, which is why random operands are mixed with directed carry, overflow and wrap cases. A wrong write strobe or a flag that should have passed through unchanged is caught for compare, bit-test and the reserved codes.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int OPW = 4;

  typedef enum logic [OPW-1:0] {
    OP_OR  = 4'd0,
    OP_AND = 4'd1,
    OP_XOR = 4'd2,
    OP_ADD = 4'd3,
    OP_SUB = 4'd4,
    OP_CMP = 4'd5,
    OP_INC = 4'd6,
    OP_DEC = 4'd7,
    OP_SHL = 4'd8,
    OP_ROL = 4'd9,
    OP_SHR = 4'd10,
    OP_ROR = 4'd11,
    OP_TST = 4'd12
  } op_e;
endpackage

// File: rtl/alu8_logic.sv
module alu8_logic #(
  parameter int WIDTH = 8
) (
  input  logic [alu8_pkg::OPW-1:0] op,
  input  logic [WIDTH-1:0]         a,
  input  logic [WIDTH-1:0]         b,
  output logic [WIDTH-1:0]         y,
  output logic [WIDTH-1:0]         masked
);
  import alu8_pkg::*;

  assign masked = a & b;

  always_comb begin
    case (op)
      OP_OR:   y = a | b;
      OP_AND:  y = masked;
      default: y = a ^ b;
    endcase
  end
endmodule

// File: rtl/alu8_arith.sv
module alu8_arith #(
  parameter int WIDTH = 8
) (
  input  logic [alu8_pkg::OPW-1:0] op,
  input  logic [WIDTH-1:0]         a,
  input  logic [WIDTH-1:0]         b,
  input  logic                     cin,
  output logic [WIDTH-1:0]         sum,
  output logic                     cout,
  output logic                     vout
);
  import alu8_pkg::*;

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic             c_eff;
  logic [WIDTH:0]   full;

  always_comb begin
    case (op)
      OP_SUB:  begin b_eff = ~b;                 c_eff = cin;  end
      OP_CMP:  begin b_eff = ~b;                 c_eff = 1'b1; end
      OP_INC:  begin b_eff = '0;                 c_eff = 1'b1; end
      OP_DEC:  begin b_eff = {WIDTH{1'b1}};      c_eff = 1'b0; end
      default: begin b_eff = b;                  c_eff = cin;  end
    endcase
  end

  assign full = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, c_eff};
  assign sum  = full[WIDTH-1:0];
  assign cout = full[WIDTH];
  assign vout = (a[MSB] ^ sum[MSB]) & (b_eff[MSB] ^ sum[MSB]);
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift #(
  parameter int WIDTH = 8
) (
  input  logic [alu8_pkg::OPW-1:0] op,
  input  logic [WIDTH-1:0]         a,
  input  logic                     cin,
  output logic [WIDTH-1:0]         y,
  output logic                     cout
);
  import alu8_pkg::*;

  localparam int MSB = WIDTH - 1;

  logic fill;

  assign fill = ((op == OP_ROL) || (op == OP_ROR)) ? cin : 1'b0;

  always_comb begin
    if ((op == OP_SHL) || (op == OP_ROL)) begin
      y    = {a[MSB-1:0], fill};
      cout = a[MSB];
    end else begin
      y    = {fill, a[MSB:1]};
      cout = a[0];
    end
  end
endmodule

// File: rtl/alu8_top.sv
module alu8_top #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       op_sel,
  input  logic [WIDTH-1:0] acc_in,
  input  logic [WIDTH-1:0] mem_in,
  input  logic             carry_in,
  input  logic             ovf_in,
  output logic [WIDTH-1:0] res_q,
  output logic             c_q,
  output logic             z_q,
  output logic             v_q,
  output logic             n_q,
  output logic             wr_q
);
  import alu8_pkg::*;

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] lg_y, lg_mask, ar_sum, sh_y;
  logic             ar_c, ar_v, sh_c;

  logic [WIDTH-1:0] r_d, zn_src;
  logic             c_d, v_d, n_d, wr_d;

  alu8_logic #(.WIDTH(WIDTH)) u_logic (
    .op(op_sel), .a(acc_in), .b(mem_in), .y(lg_y), .masked(lg_mask)
  );

  alu8_arith #(.WIDTH(WIDTH)) u_arith (
    .op(op_sel), .a(acc_in), .b(mem_in), .cin(carry_in),
    .sum(ar_sum), .cout(ar_c), .vout(ar_v)
  );

  alu8_shift #(.WIDTH(WIDTH)) u_shift (
    .op(op_sel), .a(acc_in), .cin(carry_in), .y(sh_y), .cout(sh_c)
  );

  always_comb begin
    r_d    = acc_in;
    zn_src = acc_in;
    c_d    = carry_in;
    v_d    = ovf_in;
    n_d    = 1'b0;
    wr_d   = 1'b1;
    case (op_sel)
      OP_OR, OP_AND, OP_XOR: begin
        r_d = lg_y;    zn_src = lg_y;
      end
      OP_ADD, OP_SUB: begin
        r_d = ar_sum;  zn_src = ar_sum; c_d = ar_c; v_d = ar_v;
      end
      OP_CMP: begin
        r_d = ar_sum;  zn_src = ar_sum; c_d = ar_c; wr_d = 1'b0;
      end
      OP_INC, OP_DEC: begin
        r_d = ar_sum;  zn_src = ar_sum;
      end
      OP_SHL, OP_ROL, OP_SHR, OP_ROR: begin
        r_d = sh_y;    zn_src = sh_y;   c_d = sh_c;
      end
      OP_TST: begin
        zn_src = lg_mask; v_d = mem_in[MSB-1]; wr_d = 1'b0;
      end
      default: begin
        wr_d = 1'b0;
      end
    endcase
    n_d = (op_sel == OP_TST) ? mem_in[MSB] : zn_src[MSB];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
      c_q   <= 1'b0;
      z_q   <= 1'b0;
      v_q   <= 1'b0;
      n_q   <= 1'b0;
      wr_q  <= 1'b0;
    end else begin
      res_q <= r_d;
      c_q   <= c_d;
      z_q   <= (zn_src == '0);
      v_q   <= v_d;
      n_q   <= n_d;
      wr_q  <= wr_d;
    end
  end
endmodule

// File: rtl/alu8_checker.sv
module alu8_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [3:0]       op_sel,
  input logic [WIDTH-1:0] acc_in,
  input logic [WIDTH-1:0] mem_in,
  input logic             carry_in,
  input logic             ovf_in,
  input logic [WIDTH-1:0] res_q,
  input logic             c_q,
  input logic             z_q,
  input logic             v_q,
  input logic             n_q,
  input logic             wr_q
);
  logic armed;

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  AST_LOGIC_PASS: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(op_sel) <= 4'd2) |-> (c_q == $past(carry_in) && v_q == $past(ovf_in) && wr_q)); // R3

  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(op_sel) == 4'd5) |-> (!wr_q && c_q == ($past(acc_in) >= $past(mem_in)))); // R6

  AST_STEP_KEEPS_CARRY: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(op_sel) == 4'd6 || $past(op_sel) == 4'd7) |-> (c_q == $past(carry_in) && v_q == $past(ovf_in))); // R7

  AST_TST_FLAGS: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(op_sel) == 4'd12) |-> (n_q == $past(mem_in[WIDTH-1]) && v_q == $past(mem_in[WIDTH-2]) && !wr_q)); // R10

  AST_SPARE_CODE: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(op_sel) >= 4'd13) |-> (!wr_q && res_q == $past(acc_in))); // R11

  AST_SHL_CARRY: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(op_sel) == 4'd8 || $past(op_sel) == 4'd9) |-> (c_q == $past(acc_in[WIDTH-1]))); // R8

  AST_SHR_CARRY: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(op_sel) == 4'd10 || $past(op_sel) == 4'd11) |-> (c_q == $past(acc_in[0]))); // R9
endmodule

bind alu8_top alu8_checker #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .op_sel(op_sel), .acc_in(acc_in), .mem_in(mem_in),
  .carry_in(carry_in), .ovf_in(ovf_in), .res_q(res_q), .c_q(c_q), .z_q(z_q),
  .v_q(v_q), .n_q(n_q), .wr_q(wr_q)
);

// File: tb/tb_alu8_top.sv
module tb_alu8_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] op_sel = '0;
  logic [7:0] acc_in = '0, mem_in = '0;
  logic       carry_in = 1'b0, ovf_in = 1'b0;
  logic [7:0] res_q;
  logic       c_q, z_q, v_q, n_q, wr_q;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  alu8_top dut (
    .clk(clk), .rst(rst), .op_sel(op_sel), .acc_in(acc_in), .mem_in(mem_in),
    .carry_in(carry_in), .ovf_in(ovf_in), .res_q(res_q), .c_q(c_q), .z_q(z_q),
    .v_q(v_q), .n_q(n_q), .wr_q(wr_q)
  );

  // packed expectation {res, c, z, v, n, wr}
  function automatic logic [12:0] model(input int op, input int a, input int m,
                                        input bit c, input bit v);
    int r, s, bb;
    bit co, vo, zo, no, wr;
    r = a; co = c; vo = v; wr = 1'b1;
    zo = (a == 0); no = a[7];
    case (op)
      0, 1, 2: begin
        r = (op == 0) ? (a | m) : (op == 1) ? (a & m) : (a ^ m);
      end
      3, 4: begin
        bb = (op == 4) ? (~m & 255) : m;
        s  = a + bb + int'(c);
        r  = s & 255;
        co = (s > 255);
        vo = (((a ^ r) & (bb ^ r)) >> 7) & 1;
      end
      5: begin r = (a - m) & 255; co = (a >= m); wr = 1'b0; end
      6: r = (a + 1) & 255;
      7: r = (a - 1) & 255;
      8, 9: begin
        r  = ((a << 1) & 255) | ((op == 9 && c) ? 1 : 0);
        co = a[7];
      end
      10, 11: begin
        r  = (a >> 1) | ((op == 11 && c) ? 128 : 0);
        co = a[0];
      end
      12: begin wr = 1'b0; end
      default: wr = 1'b0;
    endcase
    if (op == 12) begin
      zo = ((a & m) == 0); no = m[7]; vo = m[6];
    end else begin
      zo = ((r & 255) == 0); no = r[7];
    end
    model = {r[7:0], co, zo, vo, no, wr};
  endfunction

  function automatic string tag(input int op);
    case (op)
      0, 1, 2: tag = "R3";
      3:       tag = "R4";
      4:       tag = "R5";
      5:       tag = "R6";
      6, 7:    tag = "R7";
      8, 9:    tag = "R8";
      10, 11:  tag = "R9";
      12:      tag = "R10";
      default: tag = "R11";
    endcase
  endfunction

  task automatic apply(input int op, input int a, input int m, input bit c, input bit v);
    logic [12:0] exp_v, got;
    op_sel = op[3:0]; acc_in = a[7:0]; mem_in = m[7:0]; carry_in = c; ovf_in = v;
    exp_v = model(op, a, m, c, v);
    @(negedge clk);
    got = {res_q, c_q, z_q, v_q, n_q, wr_q};
    checks++;
    if (got !== exp_v) begin
      errors++;
      $display("FAIL %s R2 op=%0d a=%h m=%h c=%0b v=%0b got=%h exp=%h",
               tag(op), op, a, m, c, v, got, exp_v);
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seed = 32'h5EED;
    void'($urandom(seed));
    // R1: reset state, driven with nonzero inputs
    op_sel = 4'd3; acc_in = 8'hFF; mem_in = 8'h01; carry_in = 1'b1; ovf_in = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if ({res_q, c_q, z_q, v_q, n_q, wr_q} !== 13'd0) begin
      errors++;
      $display("FAIL R1 reset got=%h exp=0", {res_q, c_q, z_q, v_q, n_q, wr_q});
    end
    rst = 1'b0;

    // directed corners
    apply(3, 8'h7F, 8'h01, 0, 0);  // R4 signed overflow
    apply(3, 8'hFF, 8'h00, 1, 0);  // R4 carry out, zero
    apply(3, 8'h80, 8'h80, 0, 0);  // R4 carry and overflow
    apply(4, 8'h80, 8'h01, 1, 0);  // R5 overflow on subtract
    apply(4, 8'h00, 8'h01, 1, 0);  // R5 borrow
    apply(4, 8'h05, 8'h05, 0, 1);  // R5 carry low means extra one
    apply(5, 8'h42, 8'h42, 0, 1);  // R6 equal
    apply(5, 8'h01, 8'hFF, 1, 0);  // R6 less
    apply(6, 8'hFF, 8'h00, 1, 1);  // R7 wrap up
    apply(7, 8'h00, 8'h00, 0, 0);  // R7 wrap down
    apply(8, 8'h80, 8'h00, 1, 0);  // R8 shift out, fill zero
    apply(9, 8'h80, 8'h00, 1, 0);  // R8 rotate in carry
    apply(10, 8'h01, 8'h00, 1, 1); // R9 shift out, zero
    apply(11, 8'h01, 8'h00, 1, 0); // R9 rotate carry into bit 7
    apply(12, 8'h3F, 8'hC0, 1, 0); // R10 zero set, n v from operand
    apply(12, 8'hFF, 8'h01, 0, 1); // R10 zero clear, n v cleared
    apply(0, 8'h00, 8'h00, 1, 1);  // R3 zero result keeps c v
    apply(13, 8'h80, 8'h12, 1, 0); // R11 spare code
    apply(15, 8'h00, 8'hFF, 0, 1); // R11 spare code

    // random mix
    for (int i = 0; i < 40000; i++) begin
      int op;
      op = ($urandom % 20 == 0) ? 13 + ($urandom % 3) : ($urandom % 13);
      apply(op, $urandom & 255, $urandom & 255, $urandom & 1, $urandom & 1);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule